// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This core runs programs that name no registers. It fetches one- and two-word instructions from a single word-addressed memory through one synchronous port. All arithmetic uses an internal operand stack of eight 16-bit entries. A program loads operands onto the stack, combines the top two entries with an addition or a multiplication, and writes the top entry back to memory.

The core has two architectural counters. One counts instruction-word fetches and the other counts data-word transfers, so the memory traffic of a program can be read off after it stops. The core stops on a HALT instruction. It also stops on a stack fault or an unknown opcode, and raises a sticky flag that names the cause.

Top module: `stack_cpu`

## Requirements
- R1: While `rst` is high, both counters and all three fault flags read 0, `halted` is 0, and no memory strobe is asserted. In the first cycle after `rst` falls, the core issues a read at address 0.
- R2: The opcode is in bits [3:0] of the first instruction word, and bits [15:4] are ignored. The codes are 0 = HALT, 1 = PUSH, 2 = POP, 3 = ADD and 4 = MUL. The operand address of PUSH and POP is the word that immediately follows the opcode word.
- R3: PUSH reads the data word at its operand address and places it on top of the stack.
- R4: POP writes the top-of-stack value to its operand address and removes that entry from the stack.
- R5: ADD replaces the top two entries with their sum, taken modulo 2^16.
- R6: MUL replaces the top two entries with the low 16 bits of their product.
- R7: The instruction counter rises by exactly one for each instruction-word fetch. This includes the fetch of the HALT word. The data counter rises by exactly one for each data-word read or write. A PUSH or POP costs 2 + 1 accesses, and an ADD or MUL costs 1 + 0.
- R8: Each memory access occupies its own cycle, and a read and a write are never requested in the same cycle.
- R9: ADD or MUL with fewer than two entries on the stack, or POP on an empty stack, sets the sticky `underflowFlag` and halts. The faulting instruction does not fetch its operand word.
- R10: A PUSH while eight entries are held sets the sticky `overflowFlag` and halts without fetching its operand word.
- R11: An opcode outside 0..4 sets the sticky `badOpFlag` and halts.
- R12: Once `halted` is high, it stays high until reset, no memory strobe is asserted, and both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 16 | Word address of the current access |
| memRdata | input | 16 | Read data, valid one cycle after a read strobe |
| memWdata | output | 16 | Write data, valid together with `memWr` |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| halted | output | 1 | High once the core has stopped |
| underflowFlag | output | 1 | Sticky stack underflow fault |
| overflowFlag | output | 1 | Sticky stack overflow fault |
| badOpFlag | output | 1 | Sticky unknown-opcode fault |
| instrCount | output | 32 | Instruction-word fetch count |
| dataCount | output | 32 | Data-word transfer count |

## Verification
The assertions take for granted that the attached memory returns read data exactly one cycle after a read strobe and that `rst` is held for at least one clock edge. The counter-step properties also rely on this: every strobe the core issues is accepted in its own cycle, with no stall. The bench models memory as a synchronous array with fixed one-cycle latency, which stays within these limits. Each scenario is loaded while reset is held and then runs free to its halt.

// File: rtl/stack_cpu_pkg.sv
package stack_cpu_pkg;

  typedef enum logic [3:0] {
    OP_HALT = 4'd0,
    OP_PUSH = 4'd1,
    OP_POP  = 4'd2,
    OP_ADD  = 4'd3,
    OP_MUL  = 4'd4
  } op_e;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic incPc;       // advance the program counter
    logic incInstr;    // count an instruction-word fetch
    logic incData;     // count a data-word transfer
    logic useOperand;  // address the memory with the fetched operand word
    logic pushMem;     // push the returned read data
    logic popStore;    // drop top of stack after it was stored
    logic doAdd;       // replace top two with sum
    logic doMul;       // replace top two with product
  } ctrl_t;

endpackage

// File: rtl/stack_cpu_dp.sv
module stack_cpu_dp
  import stack_cpu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctrl_t                      ctrl,
  input  logic [DW-1:0]              memRdata,
  output logic [AW-1:0]              memAddr,
  output logic [DW-1:0]              memWdata,
  output logic [$clog2(DEPTH):0]     spCount,
  output logic [CW-1:0]              instrCount,
  output logic [CW-1:0]              dataCount
);
  localparam int PW = $clog2(DEPTH);
  localparam int SW = PW + 1;

  logic [DW-1:0]   stackMem [DEPTH];
  logic [SW-1:0]   sp;
  logic [AW-1:0]   pc;
  logic [SW-1:0]   spM1, spM2;
  logic [DW-1:0]   tos, nos, aluOut;
  logic [2*DW-1:0] prod;

  assign spM1 = sp - SW'(1);
  assign spM2 = sp - SW'(2);
  assign tos  = stackMem[spM1[PW-1:0]];
  assign nos  = stackMem[spM2[PW-1:0]];
  assign prod = {{DW{1'b0}}, tos} * {{DW{1'b0}}, nos};
  assign aluOut = ctrl.doMul ? prod[DW-1:0] : DW'(tos + nos);

  // operand word is an address; AW must not exceed DW
  assign memAddr  = ctrl.useOperand ? memRdata[AW-1:0] : pc;
  assign memWdata = tos;
  assign spCount  = sp;

  always_ff @(posedge clk) begin
    if (ctrl.pushMem)
      stackMem[sp[PW-1:0]] <= memRdata;
    else if (ctrl.doAdd || ctrl.doMul)
      stackMem[spM2[PW-1:0]] <= aluOut;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp         <= '0;
      pc         <= '0;
      instrCount <= '0;
      dataCount  <= '0;
    end else begin
      if (ctrl.incPc)    pc         <= pc + AW'(1);
      if (ctrl.incInstr) instrCount <= instrCount + CW'(1);
      if (ctrl.incData)  dataCount  <= dataCount + CW'(1);
      if (ctrl.pushMem)
        sp <= sp + SW'(1);
      else if (ctrl.popStore || ctrl.doAdd || ctrl.doMul)
        sp <= spM1;
    end
  end
endmodule

// File: rtl/stack_cpu_ctrl.sv
module stack_cpu_ctrl
  import stack_cpu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DW-1:0]          memRdata,
  input  logic [$clog2(DEPTH):0] spCount,
  output ctrl_t                  ctrl,
  output logic                   memRd,
  output logic                   memWr,
  output logic                   halted,
  output logic                   underflowFlag,
  output logic                   overflowFlag,
  output logic                   badOpFlag
);
  localparam int SW = $clog2(DEPTH) + 1;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_OPERAND, ST_LOAD, ST_HALT
  } state_e;

  state_e state, nextState;
  op_e    opReg, curOp;
  logic   rdReq, wrReq;
  logic   setUnf, setOvf, setBad;

  assign curOp = op_e'(memRdata[3:0]);

  always_comb begin
    ctrl      = '0;
    rdReq     = 1'b0;
    wrReq     = 1'b0;
    setUnf    = 1'b0;
    setOvf    = 1'b0;
    setBad    = 1'b0;
    nextState = state;
    unique case (state)
      ST_FETCH: begin
        rdReq         = 1'b1;
        ctrl.incPc    = 1'b1;
        ctrl.incInstr = 1'b1;
        nextState     = ST_DECODE;
      end
      ST_DECODE: begin
        case (curOp)
          OP_HALT: nextState = ST_HALT;
          OP_PUSH, OP_POP: begin
            if (curOp == OP_PUSH && spCount == SW'(DEPTH)) begin
              setOvf    = 1'b1;
              nextState = ST_HALT;
            end else if (curOp == OP_POP && spCount == '0) begin
              setUnf    = 1'b1;
              nextState = ST_HALT;
            end else begin
              rdReq         = 1'b1;
              ctrl.incPc    = 1'b1;
              ctrl.incInstr = 1'b1;
              nextState     = ST_OPERAND;
            end
          end
          OP_ADD, OP_MUL: begin
            if (spCount < SW'(2)) begin
              setUnf    = 1'b1;
              nextState = ST_HALT;
            end else begin
              ctrl.doAdd = (curOp == OP_ADD);
              ctrl.doMul = (curOp == OP_MUL);
              nextState  = ST_FETCH;
            end
          end
          default: begin
            setBad    = 1'b1;
            nextState = ST_HALT;
          end
        endcase
      end
      ST_OPERAND: begin
        ctrl.useOperand = 1'b1;
        ctrl.incData    = 1'b1;
        if (opReg == OP_PUSH) begin
          rdReq     = 1'b1;
          nextState = ST_LOAD;
        end else begin
          wrReq         = 1'b1;
          ctrl.popStore = 1'b1;
          nextState     = ST_FETCH;
        end
      end
      ST_LOAD: begin
        ctrl.pushMem = 1'b1;
        nextState    = ST_FETCH;
      end
      default: nextState = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_FETCH;
      opReg         <= OP_HALT;
      underflowFlag <= 1'b0;
      overflowFlag  <= 1'b0;
      badOpFlag     <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_DECODE) opReg <= curOp;
      if (setUnf) underflowFlag <= 1'b1;
      if (setOvf) overflowFlag  <= 1'b1;
      if (setBad) badOpFlag     <= 1'b1;
    end
  end

  assign memRd  = rdReq & ~rst;
  assign memWr  = wrReq & ~rst;
  assign halted = (state == ST_HALT);
endmodule

// File: rtl/stack_cpu.sv
module stack_cpu
  import stack_cpu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] memAddr,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] memWdata,
  output logic          memRd,
  output logic          memWr,
  output logic          halted,
  output logic          underflowFlag,
  output logic          overflowFlag,
  output logic          badOpFlag,
  output logic [CW-1:0] instrCount,
  output logic [CW-1:0] dataCount
);
  ctrl_t                  ctrl;
  logic [$clog2(DEPTH):0] spCount;

  stack_cpu_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .memRdata(memRdata), .spCount(spCount),
    .ctrl(ctrl), .memRd(memRd), .memWr(memWr), .halted(halted),
    .underflowFlag(underflowFlag), .overflowFlag(overflowFlag),
    .badOpFlag(badOpFlag)
  );

  stack_cpu_dp #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .CW(CW)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .spCount(spCount),
    .instrCount(instrCount), .dataCount(dataCount)
  );
endmodule

// File: rtl/stack_cpu_chk.sv
module stack_cpu_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          memRd,
  input logic          memWr,
  input logic          halted,
  input logic          underflowFlag,
  input logic          overflowFlag,
  input logic          badOpFlag,
  input logic [CW-1:0] instrCount,
  input logic [CW-1:0] dataCount
);
  logic [CW-1:0] total;
  assign total = instrCount + dataCount;

  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(memRd && memWr));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (memRd || memWr) |=> (total == $past(total) + CW'(1)));

  // R7
  count_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(memRd || memWr) |=> $stable(total));

  // R12
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R12
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!memRd && !memWr));

  // R9
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underflowFlag |=> underflowFlag);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflowFlag |=> overflowFlag);

  // R11
  bad_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    badOpFlag |=> badOpFlag);

  // R9
  fault_halts_chk: assert property (@(posedge clk) disable iff (rst)
    (underflowFlag || overflowFlag || badOpFlag) |-> halted);
endmodule

bind stack_cpu stack_cpu_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .memRd(memRd), .memWr(memWr), .halted(halted),
  .underflowFlag(underflowFlag), .overflowFlag(overflowFlag),
  .badOpFlag(badOpFlag), .instrCount(instrCount), .dataCount(dataCount)
);

// File: tb/sim_stack_cpu.sv
module sim_stack_cpu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] memAddr, memRdata, memWdata;
  logic        memRd, memWr, halted;
  logic        underflowFlag, overflowFlag, badOpFlag;
  logic [31:0] instrCount, dataCount;

  logic [15:0] mem [256];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memRd) memRdata <= mem[memAddr[7:0]];
    if (memWr) mem[memAddr[7:0]] <= memWdata;
  end

  stack_cpu u0 (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRdata(memRdata),
    .memWdata(memWdata), .memRd(memRd), .memWr(memWr), .halted(halted),
    .underflowFlag(underflowFlag), .overflowFlag(overflowFlag),
    .badOpFlag(badOpFlag), .instrCount(instrCount), .dataCount(dataCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
  endtask

  // reset is held while a program is loaded; released at a falling edge
  task automatic startRun();
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic enterReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic waitHalt();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (halted) return;
    end
    check(1'b0, "R12 halt reached", 0, 1);
  endtask

  task automatic testReset();
    enterReset();
    // R1: state while reset is held
    check(instrCount == 0 && dataCount == 0, "R1 counters", instrCount, 0);
    check(!underflowFlag && !overflowFlag && !badOpFlag && !halted,
          "R1 flags", {underflowFlag, overflowFlag, badOpFlag, halted}, 0);
    check(!memRd && !memWr, "R1 strobes", {memRd, memWr}, 0);
    clearMem();
    startRun();
    check(memRd && memAddr == 16'h0, "R1 first fetch", memAddr, 0);
  endtask

  // PUSH A, PUSH B, ADD, PUSH C, PUSH D, ADD, MUL, POP X, HALT
  task automatic testExpr(input logic [15:0] a, b, c, d);
    logic [15:0] exp;
    enterReset();
    clearMem();
    mem[0] = 16'hA001; mem[1] = 16'h40;   // R2 upper bits ignored
    mem[2] = 16'h0001; mem[3] = 16'h41;
    mem[4] = 16'h0003;
    mem[5] = 16'h0001; mem[6] = 16'h42;
    mem[7] = 16'h0001; mem[8] = 16'h43;
    mem[9] = 16'hF003;
    mem[10] = 16'h0004;
    mem[11] = 16'h0002; mem[12] = 16'h44;
    mem[13] = 16'h0000;
    mem[16'h40] = a; mem[16'h41] = b; mem[16'h42] = c; mem[16'h43] = d;
    mem[16'h44] = 16'h1234;
    exp = 16'(16'(a + b) * 16'(c + d));
    startRun();
    waitHalt();
    // R3 R4 R5 R6: result stored by POP
    check(mem[16'h44] == exp, "R3 R4 R5 R6 result", mem[16'h44], exp);
    // R7: 13 words for the eight instructions plus the HALT word
    check(instrCount == 14, "R7 instr count", instrCount, 14);
    check(dataCount == 5, "R7 data count", dataCount, 5);
    check(!underflowFlag && !overflowFlag && !badOpFlag, "R2 no fault",
          {underflowFlag, overflowFlag, badOpFlag}, 0);
  endtask

  task automatic testArithUnderflow();
    enterReset();
    clearMem();
    mem[0] = 16'h0001; mem[1] = 16'h40; mem[2] = 16'h0004; mem[16'h40] = 16'h7;
    startRun();
    waitHalt();
    check(underflowFlag == 1'b1, "R9 MUL one entry", underflowFlag, 1);
    check(instrCount == 3 && dataCount == 1, "R9 counts", instrCount, 3);
  endtask

  task automatic testPopUnderflow();
    enterReset();
    clearMem();
    mem[0] = 16'h0002; mem[1] = 16'h44; mem[16'h44] = 16'h1234;
    startRun();
    waitHalt();
    check(underflowFlag == 1'b1, "R9 POP empty", underflowFlag, 1);
    check(instrCount == 1 && dataCount == 0, "R9 no operand fetch", instrCount, 1);
    check(mem[16'h44] == 16'h1234, "R9 no write", mem[16'h44], 16'h1234);
  endtask

  task automatic testOverflow();
    enterReset();
    clearMem();
    for (int i = 0; i < 9; i++) begin
      mem[2*i] = 16'h0001; mem[2*i+1] = 16'h40;
    end
    startRun();
    waitHalt();
    check(overflowFlag == 1'b1, "R10 ninth push", overflowFlag, 1);
    check(instrCount == 17, "R10 instr count", instrCount, 17);
    check(dataCount == 8, "R10 data count", dataCount, 8);
    check(!underflowFlag, "R10 no underflow", underflowFlag, 0);
  endtask

  task automatic testBadOp();
    enterReset();
    clearMem();
    mem[0] = 16'h0007;
    startRun();
    waitHalt();
    check(badOpFlag == 1'b1, "R11 opcode 7", badOpFlag, 1);
    check(instrCount == 1 && dataCount == 0, "R11 counts", instrCount, 1);
  endtask

  task automatic testHaltHold();
    int ic, dc;
    ic = instrCount; dc = dataCount;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (memRd || memWr || !halted) begin
        check(1'b0, "R12 quiet", {memRd, memWr, halted}, 1);
        return;
      end
    end
    check(instrCount == ic && dataCount == dc, "R12 counters hold", instrCount, ic);
    check(halted, "R12 still halted", halted, 1);
  endtask

  initial begin
    clearMem();
    testReset();
    testExpr(16'd3, 16'd5, 16'd7, 16'd2);
    testHaltHold();
    testExpr(16'hFFFF, 16'h0004, 16'h7000, 16'h1000);
    testArithUnderflow();
    testPopUnderflow();
    testOverflow();
    testHaltHold();
    testBadOp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual %0d expected %0d", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule